// File: doc/BRIEF.md
# Edge-Triggered Non-Maskable Interrupt Entry Sequencer

This block watches an active-low non-maskable interrupt pin and turns every high-to-low transition into a pending request. A pin held low after its edge has been taken raises nothing more. The request waits until the core reports that the current instruction has finished. At that point the block takes over the bus and runs the entry sequence. It saves the program bank, both program counter bytes and the status byte to the stack in bank 00, decrementing the stack pointer once per byte. It then fetches a two-byte handler address from a location that depends on whether the core runs in emulation or native mode. It presents the new program counter with a one-cycle load strobe, and the core treats the program bank as 00 from then on.

The pin is first brought into the clock domain through a synchronizer chain. A new edge that arrives while an entry is already running sets the request again, so a second entry follows straight after the first one. The bus is simple. The address, write data and write strobe are registered. Read data is sampled in the same cycle the address is presented.

Top module: `nmi_entry_seq`

## Requirements
- R1: Only a high-to-low transition on `nmi_n` raises a request; holding `nmi_n` low after its edge has been serviced produces no further entry.
- R2: A falling edge on `nmi_n` that arrives while an entry sequence is running causes exactly one more entry sequence after the current one.
- R3: While `insn_done` is low, a pending request does not start an entry; `busy` rises only in the cycle after `insn_done` was sampled high with a request pending.
- R4: An entry begins with four consecutive cycles of `wr_en` high whose `wr_data` is, in order, `bank_in`, `pc_in[15:8]`, `pc_in[7:0]`, `status_in` (values captured when the entry starts).
- R5: The four writes go to addresses `{8'h00, sp}`, `{8'h00, sp-1}`, `{8'h00, sp-2}`, `{8'h00, sp-3}`, where `sp` is `sp_in` at the start of the entry.
- R6: After the writes come two read cycles with `wr_en` low, addressing 0x00FFFA then 0x00FFFB when `emu_mode` is 1, or 0x00FFEA then 0x00FFEB when `emu_mode` is 0.
- R7: In the cycle after the second read, `pc_load` is high for one cycle, `busy` is low and `new_pc` equals `{byte read second, byte read first}`.
- R8: With `insn_done` held high, `busy` is first high after the fourth rising clock edge following the fall of `nmi_n` (two synchronizer stages, one edge stage, one start stage).
- R9: Synchronous reset clears the pending request and the edge history, returns the sequencer to idle and sets `busy`, `wr_en`, `pc_load`, `bus_addr`, `wr_data` and `new_pc` to zero; a request pending before reset is never serviced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_n | input | 1 | Asynchronous active-low non-maskable interrupt pin |
| insn_done | input | 1 | High in a cycle where the current instruction completes |
| emu_mode | input | 1 | 1 = emulation mode vector, 0 = native mode vector |
| bank_in | input | 8 | Current program bank |
| pc_in | input | 16 | Current program counter |
| status_in | input | 8 | Current status byte |
| sp_in | input | 16 | Current stack pointer |
| rd_data | input | 8 | Read data for the presented address |
| bus_addr | output | 24 | Bus address |
| wr_data | output | 8 | Write data |
| wr_en | output | 1 | Write strobe |
| busy | output | 1 | Entry sequence in progress |
| new_pc | output | 16 | Program counter loaded from the vector |
| pc_load | output | 1 | One-cycle strobe when `new_pc` is valid |

## Verification
The bench builds the block with its default parameters: a 24-bit address, byte data, a two-stage synchronizer and the two standard vector bases. These values make the exact entry latency, the stack addresses and the two vector pairs in both modes directly observable. Random stack pointers near and away from the 0x0000 wrap are included. Random edges are also injected at every cycle of a running entry to reach the back-to-back entry case.

// File: rtl/nmi_pkg.sv
package nmi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_BANK,
    ST_PUSH_PCH,
    ST_PUSH_PCL,
    ST_PUSH_STAT,
    ST_VEC_LO,
    ST_VEC_HI
  } seq_state_t;

endpackage

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic nmi_n,
  input  logic take,
  output logic pending
);

  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   pend_q;
  logic                   fall;

  assign fall    = prev_q & ~sync_q[MSB];
  assign pending = pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], nmi_n};
      prev_q <= sync_q[MSB];
      pend_q <= fall | (pend_q & ~take);
    end
  end

  AST_FALL_SETS_PENDING: assert property (@(posedge clk) disable iff (rst)
    fall |=> pend_q); // R2

  AST_PENDING_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> $past(fall)); // R1

endmodule

// File: rtl/nmi_entry_fsm.sv
module nmi_entry_fsm
  import nmi_pkg::*;
#(
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned VEC_EMU = 32'h0000_FFFA,
  parameter int unsigned VEC_NAT = 32'h0000_FFEA
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pending,
  input  logic                insn_done,
  input  logic                emu_mode,
  input  logic [DATA_W-1:0]   bank_in,
  input  logic [2*DATA_W-1:0] pc_in,
  input  logic [DATA_W-1:0]   status_in,
  input  logic [ADDR_W-DATA_W-1:0] sp_in,
  input  logic [DATA_W-1:0]   rd_data,
  output logic                take,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W-1:0]   wr_data,
  output logic                wr_en,
  output logic                busy,
  output logic [2*DATA_W-1:0] new_pc,
  output logic                pc_load
);

  localparam int unsigned OFS_W = ADDR_W - DATA_W;
  localparam int unsigned PC_W  = 2 * DATA_W;
  localparam logic [DATA_W-1:0] BANK0   = '0;
  localparam logic [OFS_W-1:0]  ONE_OFS = OFS_W'(1);
  localparam logic [OFS_W-1:0]  VEMU_LO = OFS_W'(VEC_EMU);
  localparam logic [OFS_W-1:0]  VEMU_HI = OFS_W'(VEC_EMU + 1);
  localparam logic [OFS_W-1:0]  VNAT_LO = OFS_W'(VEC_NAT);
  localparam logic [OFS_W-1:0]  VNAT_HI = OFS_W'(VEC_NAT + 1);

  seq_state_t          state;
  logic [OFS_W-1:0]    sp_q;
  logic [PC_W-1:0]     pc_cap;
  logic [DATA_W-1:0]   stat_cap;
  logic                emu_cap;
  logic [DATA_W-1:0]   lo_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wd_q;
  logic                we_q;
  logic                busy_q;
  logic [PC_W-1:0]     pc_q;
  logic                ld_q;

  assign take     = (state == ST_IDLE) && pending && insn_done;
  assign bus_addr = addr_q;
  assign wr_data  = wd_q;
  assign wr_en    = we_q;
  assign busy     = busy_q;
  assign new_pc   = pc_q;
  assign pc_load  = ld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      sp_q     <= '0;
      pc_cap   <= '0;
      stat_cap <= '0;
      emu_cap  <= 1'b0;
      lo_q     <= '0;
      addr_q   <= '0;
      wd_q     <= '0;
      we_q     <= 1'b0;
      busy_q   <= 1'b0;
      pc_q     <= '0;
      ld_q     <= 1'b0;
    end else begin
      ld_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (take) begin
            state    <= ST_PUSH_BANK;
            busy_q   <= 1'b1;
            we_q     <= 1'b1;
            addr_q   <= {BANK0, sp_in};
            wd_q     <= bank_in;
            sp_q     <= sp_in - ONE_OFS;
            pc_cap   <= pc_in;
            stat_cap <= status_in;
            emu_cap  <= emu_mode;
          end
        end
        ST_PUSH_BANK: begin
          state  <= ST_PUSH_PCH;
          addr_q <= {BANK0, sp_q};
          wd_q   <= pc_cap[PC_W-1:DATA_W];
          sp_q   <= sp_q - ONE_OFS;
        end
        ST_PUSH_PCH: begin
          state  <= ST_PUSH_PCL;
          addr_q <= {BANK0, sp_q};
          wd_q   <= pc_cap[DATA_W-1:0];
          sp_q   <= sp_q - ONE_OFS;
        end
        ST_PUSH_PCL: begin
          state  <= ST_PUSH_STAT;
          addr_q <= {BANK0, sp_q};
          wd_q   <= stat_cap;
          sp_q   <= sp_q - ONE_OFS;
        end
        ST_PUSH_STAT: begin
          state  <= ST_VEC_LO;
          we_q   <= 1'b0;
          wd_q   <= '0;
          addr_q <= {BANK0, emu_cap ? VEMU_LO : VNAT_LO};
        end
        ST_VEC_LO: begin
          state  <= ST_VEC_HI;
          lo_q   <= rd_data;
          addr_q <= {BANK0, emu_cap ? VEMU_HI : VNAT_HI};
        end
        ST_VEC_HI: begin
          state  <= ST_IDLE;
          pc_q   <= {rd_data, lo_q};
          ld_q   <= 1'b1;
          busy_q <= 1'b0;
          addr_q <= '0;
        end
        default: begin
          state  <= ST_IDLE;
          busy_q <= 1'b0;
          we_q   <= 1'b0;
        end
      endcase
    end
  end

  AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> busy); // R4

  AST_PUSH_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en)) |-> (bus_addr[OFS_W-1:0] == $past(bus_addr[OFS_W-1:0]) - ONE_OFS)); // R5

  AST_BUSY_BANK_ZERO: assert property (@(posedge clk) disable iff (rst)
    busy |-> (bus_addr[ADDR_W-1:OFS_W] == BANK0)); // R6

  AST_START_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(insn_done && pending)); // R3

  AST_LOAD_ENDS_ENTRY: assert property (@(posedge clk) disable iff (rst)
    pc_load |-> (!busy && $past(busy))); // R7

endmodule

// File: rtl/nmi_entry_seq.sv
module nmi_entry_seq #(
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned VEC_EMU     = 32'h0000_FFFA,
  parameter int unsigned VEC_NAT     = 32'h0000_FFEA
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     nmi_n,
  input  logic                     insn_done,
  input  logic                     emu_mode,
  input  logic [DATA_W-1:0]        bank_in,
  input  logic [2*DATA_W-1:0]      pc_in,
  input  logic [DATA_W-1:0]        status_in,
  input  logic [ADDR_W-DATA_W-1:0] sp_in,
  input  logic [DATA_W-1:0]        rd_data,
  output logic [ADDR_W-1:0]        bus_addr,
  output logic [DATA_W-1:0]        wr_data,
  output logic                     wr_en,
  output logic                     busy,
  output logic [2*DATA_W-1:0]      new_pc,
  output logic                     pc_load
);

  logic pending;
  logic take;

  nmi_edge_latch #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_edge (
    .clk     (clk),
    .rst     (rst),
    .nmi_n   (nmi_n),
    .take    (take),
    .pending (pending)
  );

  nmi_entry_fsm #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .VEC_EMU (VEC_EMU),
    .VEC_NAT (VEC_NAT)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .pending   (pending),
    .insn_done (insn_done),
    .emu_mode  (emu_mode),
    .bank_in   (bank_in),
    .pc_in     (pc_in),
    .status_in (status_in),
    .sp_in     (sp_in),
    .rd_data   (rd_data),
    .take      (take),
    .bus_addr  (bus_addr),
    .wr_data   (wr_data),
    .wr_en     (wr_en),
    .busy      (busy),
    .new_pc    (new_pc),
    .pc_load   (pc_load)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !wr_en && !pc_load)); // R9

endmodule

// File: tb/test_nmi_entry_seq.sv
module test_nmi_entry_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        nmi_n = 1'b1;
  logic        insn_done = 1'b0;
  logic        emu_mode = 1'b0;
  logic [7:0]  bank_in = '0;
  logic [15:0] pc_in = '0;
  logic [7:0]  status_in = '0;
  logic [15:0] sp_in = '0;
  logic [7:0]  rd_data;
  logic [23:0] bus_addr;
  logic [7:0]  wr_data;
  logic        wr_en;
  logic        busy;
  logic [15:0] new_pc;
  logic        pc_load;

  logic [7:0]  vemu_lo = 8'h34, vemu_hi = 8'h12, vnat_lo = 8'h78, vnat_hi = 8'h56;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  always_comb begin
    case (bus_addr)
      24'h00FFFA: rd_data = vemu_lo;
      24'h00FFFB: rd_data = vemu_hi;
      24'h00FFEA: rd_data = vnat_lo;
      24'h00FFEB: rd_data = vnat_hi;
      default:    rd_data = 8'hEE;
    endcase
  end

  nmi_entry_seq i_nmi_entry_seq (
    .clk(clk), .rst(rst), .nmi_n(nmi_n), .insn_done(insn_done),
    .emu_mode(emu_mode), .bank_in(bank_in), .pc_in(pc_in),
    .status_in(status_in), .sp_in(sp_in), .rd_data(rd_data),
    .bus_addr(bus_addr), .wr_data(wr_data), .wr_en(wr_en), .busy(busy),
    .new_pc(new_pc), .pc_load(pc_load)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [23:0] vec_addr(input bit emu, input bit hi);
    return emu ? (24'h00FFFA + 24'(hi)) : (24'h00FFEA + 24'(hi));
  endfunction

  function automatic logic [15:0] vec_pc(input bit emu);
    return emu ? {vemu_hi, vemu_lo} : {vnat_hi, vnat_lo};
  endfunction

  // Waits for an entry, checks it cycle by cycle; inj >= 0 drops nmi_n at that cycle.
  task automatic expect_entry(input int max_wait, input int inj);
    logic [7:0]  exp_d[4];
    int w = 0;
    while (!busy && w < max_wait) begin
      cyc(1);
      w++;
    end
    chk(busy, "R3", "entry started", 32'(busy), 1);
    exp_d = '{bank_in, pc_in[15:8], pc_in[7:0], status_in};
    for (int i = 0; i < 6; i++) begin
      if (i < 4) begin
        chk(wr_en == 1'b1, "R4", "push strobe", 32'(wr_en), 1);
        chk(wr_data == exp_d[i], "R4", "push data", 32'(wr_data), 32'(exp_d[i]));
        chk(bus_addr == {8'h00, 16'(sp_in - 16'(i))}, "R5", "push address",
            32'(bus_addr), 32'({8'h00, 16'(sp_in - 16'(i))}));
      end else begin
        chk(wr_en == 1'b0 && busy, "R6", "vector read strobe", 32'(wr_en), 0);
        chk(bus_addr == vec_addr(emu_mode, i == 5), "R6", "vector address",
            32'(bus_addr), 32'(vec_addr(emu_mode, i == 5)));
      end
      if (i == inj) nmi_n = 1'b0;
      cyc(1);
    end
    chk(pc_load == 1'b1 && busy == 1'b0, "R7", "load strobe with busy low",
        32'({pc_load, busy}), 32'h2);
    chk(new_pc == vec_pc(emu_mode), "R7", "new pc", 32'(new_pc), 32'(vec_pc(emu_mode)));
    cyc(1);
    chk(pc_load == 1'b0, "R7", "load strobe one cycle", 32'(pc_load), 0);
  endtask

  task automatic expect_quiet(input int n, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      cyc(1);
      if (busy) seen = 1'b1;
    end
    chk(!seen, req, "no entry", 32'(seen), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    cyc(3);
    // R9: reset values
    chk(!busy && !wr_en && !pc_load, "R9", "reset outputs", 32'({busy, wr_en, pc_load}), 0);
    chk(bus_addr == 0 && wr_data == 0 && new_pc == 0, "R9", "reset data", 32'(bus_addr), 0);
    rst = 1'b0;
    cyc(2);

    // R8: latency with insn_done high, native mode
    insn_done = 1'b1; emu_mode = 1'b0; sp_in = 16'h01FF;
    bank_in = 8'hA5; pc_in = 16'hBEEF; status_in = 8'h3C;
    nmi_n = 1'b0;
    cyc(3);
    chk(!busy, "R8", "busy before fourth edge", 32'(busy), 0);
    cyc(1);
    chk(busy, "R8", "busy after fourth edge", 32'(busy), 1);
    expect_entry(0, -1);

    // R1: held low yields nothing more
    expect_quiet(20, "R1");
    nmi_n = 1'b1;
    cyc(4);
    expect_quiet(10, "R1");

    // R3: deferred until instruction boundary, emulation mode
    insn_done = 1'b0; emu_mode = 1'b1; sp_in = 16'h0002;
    nmi_n = 1'b0; cyc(2); nmi_n = 1'b1;
    expect_quiet(15, "R3");
    insn_done = 1'b1;
    expect_entry(4, -1);

    // R9: pending request dropped by reset
    insn_done = 1'b0;
    nmi_n = 1'b0; cyc(2); nmi_n = 1'b1; cyc(5);
    rst = 1'b1; cyc(2);
    chk(!busy && !wr_en && !pc_load && new_pc == 0, "R9", "outputs in reset",
        32'({busy, wr_en, pc_load}), 0);
    rst = 1'b0; insn_done = 1'b1;
    expect_quiet(12, "R9");

    // R2: random entries, some with an edge during service
    for (int it = 0; it < 40; it++) begin
      int inj;
      emu_mode  = 1'($urandom());
      sp_in     = (it % 5 == 0) ? 16'(it % 4) : 16'($urandom());
      bank_in   = 8'($urandom());
      pc_in     = 16'($urandom());
      status_in = 8'($urandom());
      vemu_lo = 8'($urandom()); vemu_hi = 8'($urandom());
      vnat_lo = 8'($urandom()); vnat_hi = 8'($urandom());
      inj = ($urandom() % 2 == 0) ? -1 : int'($urandom() % 6);
      insn_done = 1'b0;
      nmi_n = 1'b0; cyc(2); nmi_n = 1'b1;
      cyc(int'($urandom() % 6));
      insn_done = 1'b1;
      expect_entry(12, inj);
      if (inj >= 0) begin
        expect_entry(12, -1); // R2 second entry
        nmi_n = 1'b1;
        cyc(3);
      end
      expect_quiet(8, "R2");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule